// File: doc/BRIEF.md
# Cascadable Serial-Load Latched Output Driver

This block turns a serial bit stream into ten parallel drive-enable levels. On each rising clock edge one bit enters the first stage of a ten-stage shift chain, and every stored bit moves one stage toward the serial output. A bank of latches sits behind the chain. While the strobe input is high, the latches are transparent: each one copies its shift stage and keeps tracking it. When the strobe falls, the latches keep the last value they took. A blanking input forces every output level to zero. It does this without touching the latch contents, so the same pattern returns when blanking is released.

Each output bit stands for one driver. A value of 1 means the source driver is on. A value of 0 means the pull-down sink is on. The serial output is the registered last stage of the chain. Connecting it to the serial input of a second instance that shares the clock, strobe and blanking lines gives a twenty-line driver. The latch stage is modelled as a register sampled on the system clock with a combinational bypass, so it synthesizes as ordinary flops.

Two small state decodes govern behaviour:
- The latch mode is `LAT_OPEN` when the strobe is high and `LAT_HOLD` when it is low. A rising strobe moves the mode from `LAT_HOLD` to `LAT_OPEN`, and a falling strobe moves it back.
- The output mode is `OUT_BLANK` when blanking is high and `OUT_DRIVE` when it is low. A rising blank moves the mode from `OUT_DRIVE` to `OUT_BLANK`, and a falling blank moves it back.

Top module: `srl_latch_driver`

## Requirements
- R1: A clock edge with `rst_n` low clears every shift stage and every latch to 0. After reset, all outputs are 0 (sink on) and `ser_out` is 0.
- R2: On each rising edge, `ser_in` enters stage 1 and each stage k takes the old value of stage k-1. `ser_out` shows stage 10, so a bit appears on `ser_out` after the tenth edge following its entry.
- R3: While `strobe` is high and `blank` is low, `drv_out[k-1]` equals shift stage k in the same cycle. The first bit shifted in reaches `drv_out[9]` after ten edges.
- R4: While `strobe` is low, the latches do not change, and `drv_out` stays constant even though shifting continues.
- R5: While `blank` is high, all ten `drv_out` bits are 0, whatever `strobe` and the stored data are. This includes shifting with `strobe` held high.
- R6: Blanking leaves the latch contents unchanged. When `blank` returns low, `drv_out` shows the same pattern it showed before blanking.
- R7: When `strobe` falls, the value held is the value `drv_out` showed in the last cycle `strobe` was high.
- R8: With one instance's `ser_out` wired to a second instance's `ser_in`, twenty clocks load a 20-bit stream. The bit shifted in first ends up at the second instance's `drv_out[9]`, and the bit shifted in last ends up at the first instance's `drv_out[0]`.
- R9: Each `drv_out` bit is a plain level, where 1 means the source driver is on and 0 means the pull-down sink is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | High: latches transparent; low: latches hold |
| blank | input | 1 | High: all outputs forced to 0 |
| ser_out | output | 1 | Stage 10, for cascading |
| drv_out | output | 10 | Driver levels, 1 = source on, 0 = sink on |

## Verification
The assertions check several behaviours on every cycle:
- the shift step and the serial output, each taken one edge after its source;
- transparency while the strobe is high;
- latch stability while the strobe is low;
- zero outputs while blanking is high;
- the cleared state after a reset edge.

Some behaviours only show up across many cycles, so only the bench's scenarios can show them:
- an output pattern coming back intact after a blanking interval;
- the held value matching what was shown just before the strobe fell;
- a 20-bit stream landing in the right bit positions across two chained instances.

// File: rtl/srl_drv_pkg.sv
package srl_drv_pkg;

    typedef enum logic {
        LAT_HOLD = 1'b0,
        LAT_OPEN = 1'b1
    } lat_mode_e;

    typedef enum logic {
        OUT_DRIVE = 1'b0,
        OUT_BLANK = 1'b1
    } out_mode_e;

endpackage

// File: rtl/srl_shift_chain.sv
module srl_shift_chain #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stage_q,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    // stage_q[0] is stage 1 (entry), stage_q[LAST] is nearest ser_out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= ser_in;
            for (int i = 1; i < WIDTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign ser_out = stage_q[LAST];

endmodule

// File: rtl/srl_latch_bank.sv
module srl_latch_bank
    import srl_drv_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] stage_q,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] view
);
    lat_mode_e mode;

    always_comb begin
        mode = strobe ? LAT_OPEN : LAT_HOLD;
    end

    // state register: captures while open, keeps while holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            unique case (mode)
                LAT_OPEN: latch_q <= stage_q;
                LAT_HOLD: latch_q <= latch_q;
            endcase
        end
    end

    // output process: transparent path while open
    always_comb begin
        unique case (mode)
            LAT_OPEN: view = stage_q;
            LAT_HOLD: view = latch_q;
        endcase
    end

endmodule

// File: rtl/srl_out_stage.sv
module srl_out_stage
    import srl_drv_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             blank,
    input  logic [WIDTH-1:0] view,
    output logic [WIDTH-1:0] drv_out
);
    out_mode_e omode;

    always_comb begin
        omode = blank ? OUT_BLANK : OUT_DRIVE;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_comb begin
            unique case (omode)
                OUT_DRIVE: drv_out[g] = view[g];
                OUT_BLANK: drv_out[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/srl_latch_driver.sv
module srl_latch_driver #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             strobe,
    input  logic             blank,
    output logic             ser_out,
    output logic [WIDTH-1:0] drv_out
);
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] view;

    srl_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .stage_q (stage_q),
        .ser_out (ser_out)
    );

    srl_latch_bank #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .stage_q (stage_q),
        .latch_q (latch_q),
        .view    (view)
    );

    srl_out_stage #(.WIDTH(WIDTH)) u_out (
        .blank   (blank),
        .view    (view),
        .drv_out (drv_out)
    );

endmodule

// File: rtl/srl_latch_driver_chk.sv
module srl_latch_driver_chk #(
    parameter int WIDTH = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             strobe,
    input logic             blank,
    input logic             ser_out,
    input logic [WIDTH-1:0] drv_out,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] latch_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stage_q == '0 && latch_q == '0));

    assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)});

    assert_ser_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ser_out == $past(stage_q[WIDTH-2]));

    assert_transparent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !blank) |-> drv_out == stage_q);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> latch_q == $past(latch_q));

    assert_blank_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> drv_out == '0);

    assert_drive_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !blank) |-> drv_out == latch_q);

endmodule

bind srl_latch_driver srl_latch_driver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .strobe  (strobe),
    .blank   (blank),
    .ser_out (ser_out),
    .drv_out (drv_out),
    .stage_q (stage_q),
    .latch_q (latch_q)
);

// File: tb/srl_latch_driver_bench.sv
module srl_latch_driver_bench;
    localparam int W = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic strobe = 1'b0;
    logic blank = 1'b0;
    logic mid_so, tail_so;
    logic [W-1:0] head_out, tail_out;

    srl_latch_driver #(.WIDTH(W)) u_srl_latch_driver (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe),
        .blank(blank), .ser_out(mid_so), .drv_out(head_out)
    );

    srl_latch_driver #(.WIDTH(W)) u_tail (
        .clk(clk), .rst_n(rst_n), .ser_in(mid_so), .strobe(strobe),
        .blank(blank), .ser_out(tail_so), .drv_out(tail_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [2*W-1:0] m_sh = '0;
    logic [2*W-1:0] m_lat = '0;

    // stimulus table: {ser_in, strobe, blank}
    localparam logic [2:0] VEC [24] = '{
        3'b110, 3'b010, 3'b110, 3'b110, 3'b000, 3'b100, 3'b100, 3'b000,
        3'b110, 3'b011, 3'b101, 3'b001, 3'b000, 3'b010, 3'b110, 3'b100,
        3'b000, 3'b101, 3'b111, 3'b110, 3'b010, 3'b100, 3'b000, 3'b110
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic si, input logic st, input logic bl);
        logic [2*W-1:0] view, exp;
        string req;
        @(negedge clk);
        ser_in = si; strobe = st; blank = bl;
        #1;
        view = st ? m_sh : m_lat;
        exp  = bl ? '0 : view;
        req  = bl ? "R5" : (st ? "R3" : "R4");
        check(req, head_out, exp[W-1:0]);
        check("R8", tail_out, exp[2*W-1:W]);
        check("R2", mid_so, m_sh[W-1]);
        check("R8", tail_so, m_sh[2*W-1]);
        @(posedge clk);
        if (st) m_lat = m_sh;
        m_sh = {m_sh[2*W-2:0], si};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ser_in = 1'b0; strobe = 1'b1; blank = 1'b0;
        repeat (3) @(posedge clk);
        m_sh = '0; m_lat = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #80000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [W-1:0]   pat;
        logic [2*W-1:0] chain_pat;

        // R1: reset state, checked with strobe low and high
        do_reset();
        #1;
        check("R1", head_out, 0);
        check("R1", mid_so, 0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);

        // R1: reset clears loaded state mid-run
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);
        do_reset();
        strobe = 1'b0;
        #1;
        check("R1", head_out, 0);
        check("R1", tail_out, 0);

        // table walk (R2, R3, R4, R5, R8 via the model)
        for (int i = 0; i < 24; i++) begin
            step(VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R5: shifting with strobe high and blank high keeps outputs off
        do_reset();
        for (int i = 0; i < W; i++) step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0);

        // R3: first bit in reaches drv_out[9] after ten edges; R9 level meaning
        do_reset();
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < W - 1; i++) step(1'b0, 1'b0, 1'b0);
        @(negedge clk); strobe = 1'b1; #1;
        check("R3", head_out, 10'h200);
        check("R9", head_out[W-1], 1'b1);
        @(posedge clk); m_lat = m_sh; m_sh = {m_sh[2*W-2:0], ser_in};

        // R6 / R7: pattern survives blanking; held value = last shown
        pat = 10'b1011001110;
        do_reset();
        for (int i = W - 1; i >= 0; i--) step(pat[i], 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
        @(negedge clk); ser_in = 1'b0; strobe = 1'b0; blank = 1'b0; #1;
        check("R6", head_out, pat);
        @(posedge clk); m_sh = {m_sh[2*W-2:0], 1'b0};

        // R8: 20-bit stream across two chained instances
        chain_pat = 20'hC5A93;
        do_reset();
        for (int i = 2*W - 1; i >= 0; i--) step(chain_pat[i], 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        @(negedge clk); ser_in = 1'b1; strobe = 1'b0; blank = 1'b0; #1;
        check("R8", {tail_out, head_out}, chain_pat);
        check("R7", head_out, chain_pat[W-1:0]);
        @(posedge clk); m_sh = {m_sh[2*W-2:0], 1'b1};
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);

        summary();
    end

endmodule